// File: doc/BRIEF.md
# Handshake Latch FIFO with Muller C-Element Control

This block is a first-in first-out buffer built in the self-timed style. It has no read or write pointers. A chain of Muller C-elements carries a four-phase request/acknowledge wave from the producer side to the consumer side. Each chain element also opens the data register of its own stage. A word enters the first stage when the producer raises its request. It then moves forward one stage per clock for as long as the stage ahead is free. It waits at the last stage until the consumer acknowledges it.

The block is modelled as clocked logic. Each C-element is a state register that copies its two inputs when they agree and holds its value when they differ. A stage's latch enable is high (open) only in the cycle in which that stage's C-element is about to rise. The registered C-element output is the delayed copy of that enable, and it serves as the request to the next stage. Two neighbouring stages share one word: a stage that holds a word must be followed by a stage at rest. The buffer therefore holds at most half as many words as it has stages.

A parameter chooses, per stage, whether the C-element is reset to zero or preset to one. With the default mask of zero, every element is cleared and the buffer starts empty.

Top module: `mpf_fifo`

## Requirements
- R1: Words leave at the output in the order they were accepted at the input. No word is lost and no word is duplicated.
- R2: `in_ack` rises only while `in_req` is high and falls only while `in_req` is low. Once `in_ack` has risen, it stays high for as long as `in_req` stays high.
- R3: When the consumer never acknowledges, the buffer accepts exactly `STAGES/2` words. The next word offered is not acknowledged.
- R4: During reset and after it, with the default preset mask, `in_ack` is low, `out_req` is low and the buffer is empty.
- R5: On an empty buffer, `in_ack` rises on the first clock edge after `in_req` is raised. `out_req` rises on the `STAGES`-th clock edge after `in_req` is raised.
- R6: Once `out_req` is high, it stays high and `out_data` keeps its value until `out_ack` has been raised. `out_req` falls only after `out_ack` has been high.
- R7: While the first stage cannot take a new word, `in_ack` stays low and unchanged for as long as `in_req` is held high. It changes only once the offered word has been captured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples every C-element and data register |
| rst_n | input | 1 | Active-low synchronous reset; applies the reset/preset mask |
| in_req | input | 1 | Producer request (four-phase); high means `in_data` is valid |
| in_data | input | WIDTH | Word offered by the producer; held stable while `in_req` is high and `in_ack` is low |
| in_ack | output | 1 | Acknowledge to the producer; high once the offered word is captured |
| out_req | output | 1 | Request to the consumer; high while a word waits at the last stage |
| out_data | output | WIDTH | Word presented to the consumer |
| out_ack | input | 1 | Consumer acknowledge (four-phase) |

## Verification
Every C-element is one register, so each handshake output is due exactly one edge after the inputs that cause it. The bench drives its inputs on falling edges and samples on the next falling edge. For an empty buffer it expects `in_ack` one edge after the request and `out_req` exactly `STAGES` edges after it, and it checks that `out_req` is still low one sample earlier. In the randomized phase and the full-buffer phase, no fixed latency is expected. There the bench checks at each sample that the handshake rules hold over the preceding interval, and it compares each delivered word against a queue of accepted words at the moment the output request is seen.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

   // Start-up value of a C-element state register.
   typedef enum logic {
      CE_CLEAR = 1'b0,
      CE_SET   = 1'b1
   } ce_init_e;

   // Chooses the start-up variant of stage idx from a preset mask.
   function automatic ce_init_e init_of(input logic [1023:0] mask, input int idx);
      return mask[idx] ? CE_SET : CE_CLEAR;
   endfunction

endpackage

// File: rtl/mpf_celem.sv
module mpf_celem
   import mpf_pkg::*;
#(
   parameter ce_init_e INIT = CE_CLEAR
) (
   input  logic clk,
   input  logic rst_n,
   input  logic a,
   input  logic b,
   output logic q
);

   generate
      if (INIT == CE_SET) begin : g_preset
         always_ff @(posedge clk) begin
            if (!rst_n)      q <= 1'b1;
            else if (a == b) q <= a;
         end
      end else begin : g_reset
         always_ff @(posedge clk) begin
            if (!rst_n)      q <= 1'b0;
            else if (a == b) q <= a;
         end
      end
   endgenerate

   // R2: agreeing inputs are copied into the state on the next edge
   assert_agree_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (a == b) |=> (q == $past(a)));

   // R2: disagreeing inputs leave the state untouched
   assert_disagree_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (a != b) |=> $stable(q));

endmodule

// File: rtl/mpf_stage.sv
module mpf_stage
   import mpf_pkg::*;
#(
   parameter int       WIDTH = 8,
   parameter ce_init_e INIT  = CE_CLEAR
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_in,
   input  logic             ack_in,
   input  logic [WIDTH-1:0] d_in,
   output logic             ctrl_out,
   output logic [WIDTH-1:0] d_out
);

   logic latch_open;
   logic ack_inv;

   assign ack_inv    = ~ack_in;
   // Open (transparent) only for the cycle in which the C-element rises.
   assign latch_open = req_in & ack_inv & ~ctrl_out;

   mpf_celem #(.INIT(INIT)) u_ce (
      .clk   (clk),
      .rst_n (rst_n),
      .a     (req_in),
      .b     (ack_inv),
      .q     (ctrl_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)          d_out <= '0;
      else if (latch_open) d_out <= d_in;
   end

   // R1: an opened latch is always followed by the control rising
   assert_open_then_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
      latch_open |=> ctrl_out);

   // R6: a word is not overwritten while the stage holds it
   assert_word_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_out && $past(ctrl_out)) |-> $stable(d_out));

endmodule

// File: rtl/mpf_fifo.sv
module mpf_fifo
   import mpf_pkg::*;
#(
   parameter int              STAGES      = 8,
   parameter int              WIDTH       = 8,
   parameter logic [STAGES-1:0] PRESET_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_req,
   input  logic [WIDTH-1:0] in_data,
   output logic             in_ack,
   output logic             out_req,
   output logic [WIDTH-1:0] out_data,
   input  logic             out_ack
);

   localparam int MAX_WORDS = STAGES / 2;
   localparam int LAST      = STAGES - 1;

   // Elaboration-time parameter checks.
   generate
      if (STAGES < 2 || (STAGES % 2) != 0) begin : g_bad_stages
         $error("mpf_fifo: STAGES must be even and at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("mpf_fifo: WIDTH must be at least 1");
      end
      if (STAGES > 1024) begin : g_bad_mask
         $error("mpf_fifo: STAGES above preset mask range");
      end
      if (MAX_WORDS < 1) begin : g_bad_cap
         $error("mpf_fifo: capacity below one word");
      end
   endgenerate

   // chain[0] is the producer request, chain[i+1] is stage i control,
   // chain[STAGES+1] is the consumer acknowledge.
   logic [STAGES+1:0] chain;
   logic [WIDTH-1:0]  dchain [STAGES+1];

   assign chain[0]          = in_req;
   assign chain[STAGES+1]   = out_ack;
   assign dchain[0]         = in_data;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         mpf_stage #(
            .WIDTH (WIDTH),
            .INIT  (init_of(1024'(PRESET_MASK), i))
         ) u_stage (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_in   (chain[i]),
            .ack_in   (chain[i+2]),
            .d_in     (dchain[i]),
            .ctrl_out (chain[i+1]),
            .d_out    (dchain[i+1])
         );
      end
   endgenerate

   assign in_ack   = chain[1];
   assign out_req  = chain[LAST+1];
   assign out_data = dchain[STAGES];

   // R2: acknowledge follows the producer request, never leads it
   assert_ack_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ack) |-> $past(in_req));

   assert_ack_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ack) |-> !$past(in_req));

   // R7: an occupied successor stage keeps a pending request unacknowledged
   assert_full_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_req && !in_ack && chain[2]) |=> !in_ack);

   // R6: the output request is withdrawn only after the consumer acknowledged
   assert_out_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_req) |-> $past(out_ack));

   assert_out_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_req) |-> !$past(out_ack));

   // R4: reset leaves both handshake outputs low (default mask only)
   generate
      if (PRESET_MASK == '0) begin : g_rst_chk
         assert_reset_idle_R4: assert property (@(posedge clk)
            !rst_n |=> (!in_ack && !out_req));
      end
   endgenerate

endmodule

// File: tb/mpf_fifo_bench.sv
module mpf_fifo_bench;

   localparam int CLK_PERIOD = 10;
   localparam int STAGES     = 8;
   localparam int WIDTH      = 8;
   localparam int WATCHDOG   = 100000;
   localparam int RAND_WORDS = 300;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_req = 1'b0;
   logic [WIDTH-1:0] in_data = '0;
   logic             in_ack;
   logic             out_req;
   logic [WIDTH-1:0] out_data;
   logic             out_ack = 1'b0;

   int checks = 0;
   int errors = 0;
   int sent = 0;
   int received = 0;
   bit sink_en = 1'b0;
   bit done = 1'b0;
   logic [WIDTH-1:0] exp_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   mpf_fifo #(.STAGES(STAGES), .WIDTH(WIDTH)) u_mpf_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_req   (in_req),
      .in_data  (in_data),
      .in_ack   (in_ack),
      .out_req  (out_req),
      .out_data (out_data),
      .out_ack  (out_ack)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [WIDTH-1:0] next_word();
      return WIDTH'($urandom);
   endfunction

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // Four-phase producer transfer; R2 checked while request is held.
   task automatic send(input logic [WIDTH-1:0] w, input int hold_extra);
      in_data = w;
      in_req  = 1'b1;
      do @(negedge clk); while (!in_ack);
      exp_q.push_back(w);
      sent++;
      for (int k = 0; k < hold_extra; k++) begin
         @(negedge clk);
         chk(in_ack == 1'b1, "R2", "ack dropped while request high", 32'(in_ack), 32'd1);
      end
      in_req  = 1'b0;
      in_data = next_word();
      do @(negedge clk); while (in_ack);
   endtask

   // Consumer: R1 order check, R6 output handshake checks.
   initial begin : sink
      logic             p_req = 1'b0;
      logic             p_ack = 1'b0;
      logic [WIDTH-1:0] p_data = '0;
      logic [WIDTH-1:0] e;
      forever begin
         @(negedge clk);
         if (rst_n && p_req && !p_ack) begin
            chk(out_req == 1'b1, "R6", "request withdrawn without ack", 32'(out_req), 32'd1);
            chk(out_data == p_data, "R6", "output word changed while pending", 32'(out_data), 32'(p_data));
         end
         p_req  = out_req;
         p_data = out_data;
         if (out_ack) begin
            if (!out_req) out_ack = 1'b0;
         end else if (sink_en && out_req && ($urandom % 4 != 0)) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R1", "word delivered that was never accepted", 32'(out_data), 32'd0);
            end else begin
               e = exp_q.pop_front();
               chk(out_data == e, "R1", "delivered word out of order", 32'(out_data), 32'(e));
            end
            received++;
            out_ack = 1'b1;
         end
         p_ack = out_ack;
      end
   end

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog: actual run incomplete expected completion");
         summary();
         $finish;
      end
   end

   initial begin : main
      logic [WIDTH-1:0] w;
      void'($urandom(32'd5077));
      repeat (3) @(negedge clk);
      chk(in_ack == 1'b0, "R4", "in_ack during reset", 32'(in_ack), 32'd0);
      chk(out_req == 1'b0, "R4", "out_req during reset", 32'(out_req), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(in_ack == 1'b0, "R4", "in_ack after reset", 32'(in_ack), 32'd0);
      chk(out_req == 1'b0, "R4", "out_req after reset", 32'(out_req), 32'd0);

      // R5: latency on an empty buffer, consumer disabled.
      in_data = 8'hA5;
      in_req  = 1'b1;
      @(negedge clk);
      chk(in_ack == 1'b1, "R5", "in_ack one edge after request", 32'(in_ack), 32'd1);
      exp_q.push_back(8'hA5);
      sent++;
      in_req  = 1'b0;
      repeat (STAGES - 2) @(negedge clk);
      chk(out_req == 1'b0, "R5", "out_req one edge early", 32'(out_req), 32'd0);
      @(negedge clk);
      chk(out_req == 1'b1, "R5", "out_req after STAGES edges", 32'(out_req), 32'd1);
      chk(out_data == 8'hA5, "R5", "first word at output", 32'(out_data), 32'hA5);
      sink_en = 1'b1;
      while (exp_q.size() != 0 || out_req || out_ack) @(negedge clk);

      // R3/R7: consumer stalled, fill to capacity then offer one more.
      sink_en = 1'b0;
      for (int i = 0; i < STAGES / 2; i++) send(8'h10 + 8'(i), i % 2);
      in_data = 8'h3C;
      in_req  = 1'b1;
      @(negedge clk);
      chk(in_ack == 1'b0, "R3", "word beyond capacity acknowledged", 32'(in_ack), 32'd0);
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         chk(in_ack == 1'b0, "R7", "ack moved while first stage blocked", 32'(in_ack), 32'd0);
      end
      chk(out_req == 1'b1, "R3", "full buffer presents a word", 32'(out_req), 32'd1);
      sink_en = 1'b1;
      do @(negedge clk); while (!in_ack);
      exp_q.push_back(8'h3C);
      sent++;
      in_req = 1'b0;
      do @(negedge clk); while (in_ack);

      // Mixed random traffic with random producer gaps and hold times.
      for (int i = 0; i < RAND_WORDS; i++) begin
         repeat ($urandom % 3) @(negedge clk);
         if (i % 50 == 25) begin
            sink_en = 1'b0;
            repeat (12) @(negedge clk);
            sink_en = 1'b1;
         end
         w = next_word();
         send(w, int'($urandom % 3));
      end
      while (exp_q.size() != 0 || out_req || out_ack) @(negedge clk);
      chk(received == sent, "R1", "delivered count equals accepted count", 32'(received), 32'(sent));
      chk(in_ack == 1'b0 && out_req == 1'b0, "R1", "idle after drain",
          {30'd0, in_ack, out_req}, 32'd0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule